// File: doc/BRIEF.md
# Recent-Invalidation Snoop Filter

This block sits between a coherence interconnect and a private L1 data cache. It drops snoop invalidates that cannot affect the cache. To do so it remembers line addresses that were recently snooped, and so invalidated. Those lines are known to be absent from the L1. A repeated invalidate to such a line needs no tag lookup in the cache.

The memory is a direct-mapped table. The low bits of the line address select the slot, and the remaining bits are kept as a tag beside a valid flag. When a snoop misses the table, it is forwarded to the L1 and recorded. When a snoop matches a live slot, it is filtered. When the L1 fills a line, the block is told, and it erases any slot holding that line, because the line is then present again. A flush input empties the whole table at once.

Snoops arrive with a valid/ready handshake, at most one per cycle. Each accepted snoop yields one verdict, registered one cycle later, that says whether to forward or to filter it.

Top module: `snoop_absence_filter`

## Requirements
- R1: After reset every slot is empty, no verdict is valid, and `snp_ready_o` is high.
- R2: An accepted snoop whose line is not recorded produces a forward verdict (`dec_fwd_o` = 1), and its line is then recorded.
- R3: An accepted snoop whose line is recorded in a valid slot produces a filter verdict (`dec_fwd_o` = 0), and the table is left unchanged.
- R4: A fill notification removes the slot that holds the filled line, so the next snoop to that line is forwarded.
- R5: A fill of a line that is not recorded leaves the table unchanged. This includes a line that maps to an occupied slot with a different tag.
- R6: If a fill and an accepted snoop name the same line in the same cycle, the snoop is forwarded and no slot for that line is left valid.
- R7: The slot is `line[IDX_W-1:0]` and the tag is the remaining upper bits. A recording snoop overwrites whatever line occupies its slot, so the displaced line is forwarded on its next snoop.
- R8: While `flush_i` is high, `snp_ready_o` is low and no snoop is accepted. The flush empties every slot in that single cycle.
- R9: `dec_valid_o` is high exactly in the cycle after a snoop is accepted, with `dec_line_o` equal to that snoop's line. It is low after a cycle with no accepted snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Empty the whole table this cycle |
| snp_valid_i | input | 1 | Snoop invalidate request present |
| snp_ready_o | output | 1 | Snoop can be accepted this cycle |
| snp_line_i | input | LINE_W | Line address of the snoop |
| fill_valid_i | input | 1 | L1 is loading a line this cycle |
| fill_line_i | input | LINE_W | Line address being loaded |
| dec_valid_o | output | 1 | Verdict for the snoop accepted last cycle |
| dec_fwd_o | output | 1 | 1 = forward to L1, 0 = filter |
| dec_line_o | output | LINE_W | Line address the verdict belongs to |

## Verification
The bench goes after several corner cases, each of which a faulty design would get visibly wrong:
- **Same-line race.** A fill and a snoop name the same line in the same cycle. A design that records the snoop anyway would later filter an invalidate to a line the L1 now holds, which breaks coherence.
- **Aliasing.** Lines share a slot but differ in tag. A design with a tag compare that is too narrow would filter the wrong line. A design that ignores overwrite would keep forwarding lines it should drop.
- **Fill to an unrecorded line.** This shows whether a design clears slots by index instead of by tag match, which would forward snoops it should filter.
- **Flush.** A snoop presented during a flush shows whether the design accepts it or leaves stale slots behind.

Random traffic over a small pool of lines makes hits, misses and collisions frequent.

// File: rtl/snpflt_pkg.sv
package snpflt_pkg;

  // Verdict encoding carried by the output register.
  typedef enum logic {
    VERDICT_FILTER  = 1'b0,
    VERDICT_FORWARD = 1'b1
  } snp_verdict_e;

endpackage

// File: rtl/snpflt_tag_store.sv
// Direct-mapped valid/tag table with two combinational read ports,
// one write port (snoop recording) and one clear port (fill removal).
module snpflt_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] rda_idx,
  output logic             rda_vld,
  output logic [TAG_W-1:0] rda_tag,
  input  logic [IDX_W-1:0] rdb_idx,
  output logic             rdb_vld,
  output logic [TAG_W-1:0] rdb_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  localparam int DEPTH = 1 << IDX_W;

  logic             vld_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];

  // Priority per slot: flush, then recording, then clearing.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        vld_q[e] <= 1'b0;
        tag_q[e] <= '0;
      end
    end else if (flush_i) begin
      for (int e = 0; e < DEPTH; e++) vld_q[e] <= 1'b0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (wr_en && (wr_idx == IDX_W'(e))) begin
          vld_q[e] <= 1'b1;
          tag_q[e] <= wr_tag;
        end else if (clr_en && (clr_idx == IDX_W'(e))) begin
          vld_q[e] <= 1'b0;
        end
      end
    end
  end

  assign rda_vld = vld_q[rda_idx];
  assign rda_tag = tag_q[rda_idx];
  assign rdb_vld = vld_q[rdb_idx];
  assign rdb_tag = tag_q[rdb_idx];

endmodule

// File: rtl/snpflt_probe.sv
// Splits line addresses into slot and tag and resolves matches.
module snpflt_probe #(
  parameter int LINE_W = 26,
  parameter int IDX_W  = 4,
  localparam int TAG_W = LINE_W - IDX_W
) (
  input  logic [LINE_W-1:0] snp_line,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              fill_vld,
  output logic [IDX_W-1:0]  snp_idx,
  output logic [TAG_W-1:0]  snp_tag,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [TAG_W-1:0]  fill_tag,
  input  logic              rda_vld,
  input  logic [TAG_W-1:0]  rda_tag,
  input  logic              rdb_vld,
  input  logic [TAG_W-1:0]  rdb_tag,
  output logic              snp_match,
  output logic              fill_match,
  output logic              same_line
);
  function automatic logic [IDX_W-1:0] slot_of(input logic [LINE_W-1:0] ln);
    return ln[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [LINE_W-1:0] ln);
    return ln[LINE_W-1:IDX_W];
  endfunction

  always_comb begin
    snp_idx    = slot_of(snp_line);
    snp_tag    = tag_of(snp_line);
    fill_idx   = slot_of(fill_line);
    fill_tag   = tag_of(fill_line);
    snp_match  = rda_vld && (rda_tag == snp_tag);
    fill_match = fill_vld && rdb_vld && (rdb_tag == fill_tag);
    same_line  = fill_vld && (fill_line == snp_line);
  end

endmodule

// File: rtl/snpflt_verdict_reg.sv
// One-cycle registered verdict.
module snpflt_verdict_reg
  import snpflt_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  snp_verdict_e      verdict,
  input  logic [LINE_W-1:0] line,
  output logic              dec_valid,
  output logic              dec_fwd,
  output logic [LINE_W-1:0] dec_line
);
  snp_verdict_e verdict_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      verdict_q <= VERDICT_FILTER;
      dec_line  <= '0;
    end else begin
      dec_valid <= take;
      if (take) begin
        verdict_q <= verdict;
        dec_line  <= line;
      end
    end
  end

  assign dec_fwd = (verdict_q == VERDICT_FORWARD);

endmodule

// File: rtl/snoop_absence_filter.sv
module snoop_absence_filter
  import snpflt_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              snp_valid_i,
  output logic              snp_ready_o,
  input  logic [LINE_W-1:0] snp_line_i,
  input  logic              fill_valid_i,
  input  logic [LINE_W-1:0] fill_line_i,
  output logic              dec_valid_o,
  output logic              dec_fwd_o,
  output logic [LINE_W-1:0] dec_line_o
);
  localparam int TAG_W = LINE_W - IDX_W;

  // Named internal events, also visible to the bound checker.
  logic accept;
  logic lookup_hit;
  logic alloc_en;
  logic clear_en;

  logic [IDX_W-1:0] snp_idx, fill_idx;
  logic [TAG_W-1:0] snp_tag, fill_tag;
  logic             rda_vld, rdb_vld;
  logic [TAG_W-1:0] rda_tag, rdb_tag;
  logic             snp_match, fill_match, same_line;
  snp_verdict_e     verdict;

  assign snp_ready_o = !flush_i;
  assign accept      = snp_valid_i && snp_ready_o;

  snpflt_probe #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_probe (
    .snp_line  (snp_line_i),
    .fill_line (fill_line_i),
    .fill_vld  (fill_valid_i),
    .snp_idx   (snp_idx),
    .snp_tag   (snp_tag),
    .fill_idx  (fill_idx),
    .fill_tag  (fill_tag),
    .rda_vld   (rda_vld),
    .rda_tag   (rda_tag),
    .rdb_vld   (rdb_vld),
    .rdb_tag   (rdb_tag),
    .snp_match (snp_match),
    .fill_match(fill_match),
    .same_line (same_line)
  );

  // A same-cycle fill of the snooped line makes the line present again.
  assign lookup_hit = accept && snp_match && !same_line;
  assign alloc_en   = accept && !snp_match && !same_line;
  assign clear_en   = fill_match;
  assign verdict    = lookup_hit ? VERDICT_FILTER : VERDICT_FORWARD;

  snpflt_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush_i),
    .rda_idx (snp_idx),
    .rda_vld (rda_vld),
    .rda_tag (rda_tag),
    .rdb_idx (fill_idx),
    .rdb_vld (rdb_vld),
    .rdb_tag (rdb_tag),
    .wr_en   (alloc_en),
    .wr_idx  (snp_idx),
    .wr_tag  (snp_tag),
    .clr_en  (clear_en),
    .clr_idx (fill_idx)
  );

  snpflt_verdict_reg #(.LINE_W(LINE_W)) u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (accept),
    .verdict  (verdict),
    .line     (snp_line_i),
    .dec_valid(dec_valid_o),
    .dec_fwd  (dec_fwd_o),
    .dec_line (dec_line_o)
  );

endmodule

// File: rtl/snoop_absence_filter_chk.sv
module snoop_absence_filter_chk #(
  parameter int LINE_W = 26,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_i,
  input logic              snp_valid_i,
  input logic              snp_ready_o,
  input logic [LINE_W-1:0] snp_line_i,
  input logic              fill_valid_i,
  input logic [LINE_W-1:0] fill_line_i,
  input logic              dec_valid_o,
  input logic              dec_fwd_o,
  input logic [LINE_W-1:0] dec_line_o,
  input logic              accept
);
  localparam int SLOTS = 1 << IDX_W;

  logic start_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) start_ok <= 1'b0;
    else        start_ok <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ok |-> (!dec_valid_o && snp_ready_o));

  // R8
  flush_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !snp_ready_o);

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && $past(flush_i) && accept) |=> dec_fwd_o);

  // R9
  verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid_i && snp_ready_o) |=> (dec_valid_o && dec_line_o == $past(snp_line_i)));

  // R9
  no_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_valid_i && snp_ready_o) |=> !dec_valid_o);

  // R6
  race_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fill_valid_i && fill_line_i == snp_line_i) |=> dec_fwd_o);

  // R4
  fill_then_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && $past(fill_valid_i) && accept && snp_line_i == $past(fill_line_i)) |=> dec_fwd_o);

  // R3
  repeat_filtered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && $past(accept) && accept && snp_line_i == $past(snp_line_i)
     && !$past(fill_valid_i && fill_line_i == snp_line_i)
     && !(fill_valid_i && fill_line_i == snp_line_i)) |=> !dec_fwd_o);

  initial begin
    // R7
    slot_count_chk: assert (SLOTS >= 2);
  end

endmodule

bind snoop_absence_filter snoop_absence_filter_chk #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_snoop_absence_filter.sv
module test_snoop_absence_filter;
  localparam int LW    = 26;
  localparam int IW    = 4;
  localparam int TW    = LW - IW;
  localparam int SLOTS = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush_i = 1'b0;
  logic          snp_valid_i = 1'b0;
  logic          snp_ready_o;
  logic [LW-1:0] snp_line_i = '0;
  logic          fill_valid_i = 1'b0;
  logic [LW-1:0] fill_line_i = '0;
  logic          dec_valid_o;
  logic          dec_fwd_o;
  logic [LW-1:0] dec_line_o;

  int checks = 0;
  int errors = 0;

  // Bench copy of the table, kept by its own rules.
  bit          m_live [SLOTS];
  bit [TW-1:0] m_key  [SLOTS];

  always #5 clk = ~clk;

  snoop_absence_filter #(.LINE_W(LW), .IDX_W(IW)) i_snoop_absence_filter (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .snp_valid_i(snp_valid_i), .snp_ready_o(snp_ready_o), .snp_line_i(snp_line_i),
    .fill_valid_i(fill_valid_i), .fill_line_i(fill_line_i),
    .dec_valid_o(dec_valid_o), .dec_fwd_o(dec_fwd_o), .dec_line_o(dec_line_o)
  );

  function automatic logic [LW-1:0] mk(input int key, input int slot);
    return LW'(key * SLOTS + slot);
  endfunction

  function automatic int slot_fn(input logic [LW-1:0] ln);
    return int'(ln % SLOTS);
  endfunction

  function automatic bit [TW-1:0] key_fn(input logic [LW-1:0] ln);
    return TW'(ln / SLOTS);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input bit fl, input bit sv, input logic [LW-1:0] sl,
                      input bit fv, input logic [LW-1:0] fln, input string rq);
    bit acc, same, present, e_fwd;
    int s, fs;
    flush_i = fl; snp_valid_i = sv; snp_line_i = sl;
    fill_valid_i = fv; fill_line_i = fln;
    #1;
    chk(snp_ready_o == !fl, "R8", "ready", LW'(snp_ready_o), LW'(!fl));
    s = slot_fn(sl); fs = slot_fn(fln);
    acc = sv && !fl;
    same = fv && (fln == sl);
    present = m_live[s] && (m_key[s] == key_fn(sl));
    e_fwd = !(present && !same);
    if (fl) begin
      for (int k = 0; k < SLOTS; k++) m_live[k] = 1'b0;
    end else begin
      if (fv && m_live[fs] && m_key[fs] == key_fn(fln)) m_live[fs] = 1'b0;
      if (acc && e_fwd && !same) begin
        m_live[s] = 1'b1;
        m_key[s]  = key_fn(sl);
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(dec_valid_o == acc, "R9", "dec_valid", LW'(dec_valid_o), LW'(acc));
    if (acc) begin
      chk(dec_line_o == sl, "R9", "dec_line", dec_line_o, sl);
      chk(dec_fwd_o == e_fwd, rq, "dec_fwd", LW'(dec_fwd_o), LW'(e_fwd));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [LW-1:0] a, b, c, sl, fln;
    bit fl, sv, fv;
    int seed;
    seed = 7;
    void'($urandom(seed));
    for (int k = 0; k < SLOTS; k++) begin m_live[k] = 1'b0; m_key[k] = '0; end
    a = mk(1, 3); b = mk(2, 3); c = mk(1, 5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: quiet after reset
    chk(dec_valid_o == 1'b0, "R1", "dec_valid after reset", LW'(dec_valid_o), '0);
    chk(snp_ready_o == 1'b1, "R1", "ready after reset", LW'(snp_ready_o), LW'(1));
    @(negedge clk);
    step(0, 1, a, 0, '0, "R2");   // R2 first snoop forwarded, recorded
    step(0, 1, a, 0, '0, "R3");   // R3 repeat filtered
    step(0, 0, '0, 1, a, "R4");   // R4 fill removes
    step(0, 1, a, 0, '0, "R4");
    step(0, 1, a, 0, '0, "R3");
    step(0, 0, '0, 1, b, "R5");   // R5 fill of aliasing unrecorded line
    step(0, 1, a, 0, '0, "R5");
    step(0, 1, b, 0, '0, "R7");   // R7 overwrite slot 3
    step(0, 1, a, 0, '0, "R7");
    step(0, 1, c, 1, c, "R6");    // R6 race
    step(0, 1, c, 0, '0, "R6");
    step(0, 1, c, 0, '0, "R3");
    step(1, 1, c, 0, '0, "R8");   // R8 flush, snoop not accepted
    step(0, 1, c, 0, '0, "R8");
    step(0, 1, a, 0, '0, "R8");
    for (int n = 0; n < 4000; n++) begin
      fl  = ($urandom % 40) == 0;
      sv  = ($urandom % 10) < 7;
      fv  = ($urandom % 10) < 3;
      sl  = mk(int'($urandom % 4), int'($urandom % SLOTS));
      fln = (($urandom % 3) == 0) ? sl : mk(int'($urandom % 4), int'($urandom % SLOTS));
      step(fl, sv, sl, fv, fln, "R2 R3 R4 R5 R6 R7");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule